// File: doc/BRIEF.md
# TDM Port Loopback and Channel Switch

This block sits on the serial side of a group of TDM ports and gives each port two ways to return its own received stream. The fast path copies the incoming serial bit stream of a port to the serial output of the same port through a fixed two-stage register chain, and holds the output enable high. The frame path captures each 8-bit timeslot into a double-buffered frame store. It then plays out the frame captured before, one timeslot at a time. For each outgoing timeslot a per-port control table says whether the slot is driven and which stored input timeslot of the same port feeds it. The table can therefore return a whole stream, return a subset with the rest tristated, or reorder and duplicate channels within a port.

When a port has neither loopback selected, its normal playout bit and output enable pass through unchanged. The serial interface runs one bit per clock. A TDM line has no flow control, so the data path carries no valid/ready handshake and cannot apply back-pressure: every input bit is taken on the clock edge it is presented, and every output bit is produced on schedule. The control table is written and read through a plain register port.

Top module: `tdm_loopback_switch`

## Requirements
- R1: After reset every table entry is invalid. In frame mode, no frame sync has been seen since reset, so the output enable of the port stays low and its output bit reads 0.
- R2: In fast mode the output bit equals the port's input bit from exactly two clocks earlier, and the output enable is 1 in every cycle.
- R3: When both the fast-mode bit and the frame-mode bit of a port are set, the port behaves as in fast mode.
- R4: Frame mode takes effect only when the port's channelized-mode bit is also 1. With that bit at 0, the port behaves as passthrough.
- R5: A frame sync marks frame position 0. The byte received in a timeslot is played out during the next frame. The output for frame position p appears one clock after the clock at position p.
- R6: An output timeslot whose entry has the valid bit (bit 15) clear is tristated: output enable 0 and output bit 0 for all 8 bit times of the slot.
- R7: A valid entry sends the stored byte of input timeslot src (entry bits 4:0) to its output slot. Any source may feed any output slot, including swaps and several outputs fed from one source.
- R8: With neither loopback selected, the output bit and output enable equal the playout bit and playout enable inputs in the same cycle.
- R9: Entry bits 14:5 are ignored and have no effect on the output. A table read returns the valid bit in bit 15 and the source in bits 4:0, with all other bits 0. A write shows in read data and playout from the next clock.
- R10: Timeslot s covers frame positions 8s to 8s+7, and the most significant bit of the byte comes first. The frame holds 32 timeslots, i.e. 256 positions.
- R11: A frame sync at any position restarts the position at 0 and swaps the capture and playout banks. Without a sync, the position wraps from 255 to 0 with no bank swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, one bit per port per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | High in the cycle of frame position 0 |
| ser_in | input | NPORTS | Received serial bit per port |
| play_bit | input | NPORTS | Normal playout bit per port |
| play_oe | input | NPORTS | Normal playout enable per port |
| fast_lb_en | input | NPORTS | Fast bit-level loopback select per port |
| frame_lb_en | input | NPORTS | Frame-level loopback select per port |
| chan_mode | input | NPORTS | 1 when the port carries channelized timeslots |
| cfg_we | input | 1 | Table write strobe |
| cfg_port | input | PORT_W | Table port address |
| cfg_chan | input | 5 | Table output-slot address |
| cfg_wdata | input | 16 | Table write data |
| cfg_rdata | output | 16 | Table read data for the addressed entry |
| ser_out | output | NPORTS | Transmitted serial bit per port |
| ser_oe | output | NPORTS | Output enable per port |

## Verification
A wrong frame counter or a wrong bank select shows as wrong output bits within the same or the next timeslot. A stale or misrouted frame store shows one frame later, when the captured bytes come back in the wrong slot or the wrong order. A wrong table entry shows in the first slot that uses it. A fast-path stage that is missing or added shifts every bit by one clock and is seen at once. The reference model predicts both output pins of every port on every clock. Most faults are therefore caught within one frame of 256 clocks.

// File: rtl/tdm_lb_pkg.sv
package tdm_lb_pkg;
  localparam int unsigned CFG_W         = 16;
  localparam int unsigned CFG_VALID_BIT = 15;

  typedef enum logic [1:0] {
    LB_PASS  = 2'd0,
    LB_FAST  = 2'd1,
    LB_FRAME = 2'd2
  } lb_mode_e;

  // Fast path wins over frame path; frame path needs channelized traffic.
  function automatic lb_mode_e pick_mode(input logic fast, input logic frame,
                                         input logic chan);
    if (fast)               return LB_FAST;
    else if (frame && chan) return LB_FRAME;
    else                    return LB_PASS;
  endfunction
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int unsigned POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  output logic [POS_W-1:0] pos_now,
  output logic             framed_now,
  output logic             wbank_now,
  output logic             rbank_now
);
  logic [POS_W-1:0] cnt_q;
  logic             framed_q;
  logic             wbank_q;

  always_comb begin
    pos_now    = fsync ? '0 : cnt_q + 1'b1;
    framed_now = fsync | framed_q;
    wbank_now  = fsync ? ~wbank_q : wbank_q;
    rbank_now  = ~wbank_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      framed_q <= 1'b0;
      wbank_q  <= 1'b0;
    end else begin
      cnt_q    <= pos_now;
      framed_q <= framed_now;
      wbank_q  <= wbank_now;
    end
  end
endmodule

// File: rtl/tdm_fast_path.sv
module tdm_fast_path #(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] ser_in,
  output logic [NPORTS-1:0] fast_bit
);
  logic [NPORTS-1:0] stage_q [DEPTH];

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n)     stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= ser_in;
        else            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign fast_bit = stage_q[DEPTH-1];
endmodule

// File: rtl/tdm_chan_map.sv
module tdm_chan_map
  import tdm_lb_pkg::*;
#(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned NSLOTS = 32,
  localparam int unsigned CH_W   = $clog2(NSLOTS),
  localparam int unsigned PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [CH_W-1:0]   lk_slot,
  output logic [NPORTS-1:0] lk_valid,
  output logic [CH_W-1:0]   lk_src [NPORTS]
);
  logic [NSLOTS-1:0] valid_q [NPORTS];
  logic [CH_W-1:0]   src_q   [NPORTS][NSLOTS];

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          valid_q[p] <= '0;
          for (int c = 0; c < NSLOTS; c++) src_q[p][c] <= '0;
        end else if (cfg_we && (cfg_port == PORT_W'(p))) begin
          valid_q[p][cfg_chan] <= cfg_wdata[CFG_VALID_BIT];
          src_q[p][cfg_chan]   <= cfg_wdata[CH_W-1:0];
        end
      end
      assign lk_valid[p] = valid_q[p][lk_slot];
      assign lk_src[p]   = src_q[p][lk_slot];
    end
  endgenerate

  always_comb begin
    cfg_rdata = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (cfg_port == PORT_W'(p)) begin
        cfg_rdata[CFG_VALID_BIT] = valid_q[p][cfg_chan];
        cfg_rdata[CH_W-1:0]      = src_q[p][cfg_chan];
      end
    end
  end
endmodule

// File: rtl/tdm_frame_store.sv
module tdm_frame_store #(
  parameter int unsigned NSLOTS = 32,
  parameter int unsigned SLOT_W = 8,
  localparam int unsigned CH_W  = $clog2(NSLOTS),
  localparam int unsigned BIT_W = $clog2(SLOT_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            framed,
  input  logic [CH_W-1:0] slot,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic            wbank,
  input  logic            rbank,
  input  logic            ser_in,
  input  logic            rd_valid,
  input  logic [CH_W-1:0] rd_src,
  output logic            out_bit,
  output logic            out_oe
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_W - 1);

  logic [SLOT_W-1:0] store_q [2][NSLOTS];
  logic [SLOT_W-1:0] shift_q;
  logic [SLOT_W-1:0] shift_next;
  logic [SLOT_W-1:0] rd_byte;
  logic [BIT_W-1:0]  msb_first_idx;

  assign shift_next    = {shift_q[SLOT_W-2:0], ser_in};
  assign rd_byte       = store_q[rbank][rd_src];
  assign msb_first_idx = LAST_BIT - bit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < NSLOTS; c++) store_q[b][c] <= '0;
    end else begin
      shift_q <= shift_next;
      if (framed && bit_idx == LAST_BIT) store_q[wbank][slot] <= shift_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_bit <= 1'b0;
      out_oe  <= 1'b0;
    end else if (framed) begin
      out_oe  <= rd_valid;
      out_bit <= rd_valid & rd_byte[msb_first_idx];
    end else begin
      out_oe  <= 1'b0;
      out_bit <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm_loopback_switch.sv
module tdm_loopback_switch
  import tdm_lb_pkg::*;
#(
  parameter int unsigned NPORTS     = 4,
  parameter int unsigned NSLOTS     = 32,
  parameter int unsigned SLOT_W     = 8,
  parameter int unsigned FAST_DEPTH = 2,
  localparam int unsigned CH_W   = $clog2(NSLOTS),
  localparam int unsigned BIT_W  = $clog2(SLOT_W),
  localparam int unsigned POS_W  = CH_W + BIT_W,
  localparam int unsigned PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic [NPORTS-1:0] ser_in,
  input  logic [NPORTS-1:0] play_bit,
  input  logic [NPORTS-1:0] play_oe,
  input  logic [NPORTS-1:0] fast_lb_en,
  input  logic [NPORTS-1:0] frame_lb_en,
  input  logic [NPORTS-1:0] chan_mode,
  input  logic              cfg_we,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic [NPORTS-1:0] ser_out,
  output logic [NPORTS-1:0] ser_oe
);
  logic [POS_W-1:0]  pos_now;
  logic              framed_now, wbank_now, rbank_now;
  logic [CH_W-1:0]   cur_slot;
  logic [BIT_W-1:0]  cur_bit;
  logic [NPORTS-1:0] fast_bit;
  logic [NPORTS-1:0] lk_valid;
  logic [CH_W-1:0]   lk_src [NPORTS];
  logic [NPORTS-1:0] fr_bit, fr_oe;

  assign cur_slot = pos_now[POS_W-1:BIT_W];
  assign cur_bit  = pos_now[BIT_W-1:0];

  tdm_frame_timer #(.POS_W(POS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .pos_now(pos_now), .framed_now(framed_now),
    .wbank_now(wbank_now), .rbank_now(rbank_now)
  );

  tdm_fast_path #(.NPORTS(NPORTS), .DEPTH(FAST_DEPTH)) u_fast (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .fast_bit(fast_bit)
  );

  tdm_chan_map #(.NPORTS(NPORTS), .NSLOTS(NSLOTS)) u_map (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port(cfg_port),
    .cfg_chan(cfg_chan), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lk_slot(cur_slot), .lk_valid(lk_valid), .lk_src(lk_src)
  );

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
      lb_mode_e mode;

      tdm_frame_store #(.NSLOTS(NSLOTS), .SLOT_W(SLOT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .framed(framed_now),
        .slot(cur_slot), .bit_idx(cur_bit),
        .wbank(wbank_now), .rbank(rbank_now),
        .ser_in(ser_in[p]), .rd_valid(lk_valid[p]), .rd_src(lk_src[p]),
        .out_bit(fr_bit[p]), .out_oe(fr_oe[p])
      );

      always_comb begin
        mode = pick_mode(fast_lb_en[p], frame_lb_en[p], chan_mode[p]);
        unique case (mode)
          LB_FAST: begin
            ser_out[p] = fast_bit[p];
            ser_oe[p]  = 1'b1;
          end
          LB_FRAME: begin
            ser_out[p] = fr_bit[p];
            ser_oe[p]  = fr_oe[p];
          end
          default: begin
            ser_out[p] = play_bit[p];
            ser_oe[p]  = play_oe[p];
          end
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/tdm_loopback_sva.sv
module tdm_loopback_sva #(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned PORT_W = 2,
  parameter int unsigned CH_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fsync,
  input logic [NPORTS-1:0] ser_in,
  input logic [NPORTS-1:0] play_bit,
  input logic [NPORTS-1:0] play_oe,
  input logic [NPORTS-1:0] fast_lb_en,
  input logic [NPORTS-1:0] frame_lb_en,
  input logic [NPORTS-1:0] chan_mode,
  input logic [15:0]       cfg_rdata,
  input logic [NPORTS-1:0] ser_out,
  input logic [NPORTS-1:0] ser_oe
);
  logic [1:0] since_rst;
  logic       sync_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_rst <= '0;
      sync_seen <= 1'b0;
    end else begin
      if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
      if (fsync) sync_seen <= 1'b1;
    end
  end

  assert_rdata_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[14:CH_W] == '0);

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
      assert_fast_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2 && fast_lb_en[p]) |-> ser_out[p] == $past(ser_in[p], 2));

      assert_fast_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_lb_en[p] && frame_lb_en[p]) |-> ser_oe[p]);

      assert_quiet_unframed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_seen && frame_lb_en[p] && chan_mode[p] && !fast_lb_en[p])
          |-> (!ser_oe[p] && !ser_out[p]));

      assert_tristate_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_lb_en[p] && chan_mode[p] && !fast_lb_en[p] && !ser_oe[p]) |-> !ser_out[p]);

      assert_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_lb_en[p] && !(frame_lb_en[p] && chan_mode[p]))
          |-> (ser_out[p] == play_bit[p] && ser_oe[p] == play_oe[p]));
    end
  endgenerate
endmodule

bind tdm_loopback_switch tdm_loopback_sva #(
  .NPORTS(NPORTS), .PORT_W(PORT_W), .CH_W(CH_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .ser_in(ser_in),
  .play_bit(play_bit), .play_oe(play_oe), .fast_lb_en(fast_lb_en),
  .frame_lb_en(frame_lb_en), .chan_mode(chan_mode), .cfg_rdata(cfg_rdata),
  .ser_out(ser_out), .ser_oe(ser_oe)
);

// File: tb/sim_tdm_loopback_switch.sv
module sim_tdm_loopback_switch;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fsync = 1'b0;
  logic [NP-1:0] ser_in = '0, play_bit = '0, play_oe = '0;
  logic [NP-1:0] fast_lb_en = '0, frame_lb_en = '0, chan_mode = '0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_port = '0;
  logic [4:0]    cfg_chan = '0;
  logic [15:0]   cfg_wdata = '0;
  logic [15:0]   cfg_rdata;
  logic [NP-1:0] ser_out, ser_oe;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  tdm_loopback_switch #(.NPORTS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .ser_in(ser_in),
    .play_bit(play_bit), .play_oe(play_oe), .fast_lb_en(fast_lb_en),
    .frame_lb_en(frame_lb_en), .chan_mode(chan_mode), .cfg_we(cfg_we),
    .cfg_port(cfg_port), .cfg_chan(cfg_chan), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ser_out(ser_out), .ser_oe(ser_oe)
  );

  // Behavioural reference model
  bit [7:0] m_mem [NP][2][32];
  bit [7:0] m_sh [NP];
  bit       m_tv [NP][32];
  int       m_ts [NP][32];
  bit       m_ll1 [NP], m_ll2 [NP], m_bq [NP], m_boe [NP];
  int       m_pos = 0;
  bit       m_wb = 0, m_framed = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_wb = 0; m_framed = 0;
      for (int p = 0; p < NP; p++) begin
        m_sh[p] = 0; m_ll1[p] = 0; m_ll2[p] = 0; m_bq[p] = 0; m_boe[p] = 0;
        for (int c = 0; c < 32; c++) begin
          m_tv[p][c] = 0; m_ts[p][c] = 0; m_mem[p][0][c] = 0; m_mem[p][1][c] = 0;
        end
      end
    end else begin
      bit fr_n, nwb, rb;
      int np, slot, bi, src;
      fr_n = fsync | m_framed;
      np   = fsync ? 0 : (m_pos + 1) % 256;
      nwb  = fsync ? !m_wb : m_wb;
      rb   = !nwb;
      slot = np / 8;
      bi   = np % 8;
      for (int p = 0; p < NP; p++) begin
        if (fr_n) begin
          src      = m_ts[p][slot];
          m_boe[p] = m_tv[p][slot];
          m_bq[p]  = m_tv[p][slot] ? m_mem[p][rb][src][7-bi] : 1'b0;
          if (bi == 7) m_mem[p][nwb][slot] = {m_sh[p][6:0], ser_in[p]};
        end else begin
          m_boe[p] = 0; m_bq[p] = 0;
        end
        m_sh[p]  = {m_sh[p][6:0], ser_in[p]};
        m_ll2[p] = m_ll1[p];
        m_ll1[p] = ser_in[p];
      end
      if (cfg_we) begin
        m_tv[cfg_port][cfg_chan] = cfg_wdata[15];
        m_ts[cfg_port][cfg_chan] = int'(cfg_wdata[4:0]);
      end
      m_framed = fr_n; m_pos = np; m_wb = nwb;
    end
  end

  function automatic string mode_tag(int p);
    if (fast_lb_en[p] && frame_lb_en[p]) return "R3";
    if (fast_lb_en[p]) return "R2";
    if (frame_lb_en[p] && !chan_mode[p]) return "R4";
    if (frame_lb_en[p]) return m_boe[p] ? "R7" : "R6";
    return "R8";
  endfunction

  task automatic compare_ports();
    for (int p = 0; p < NP; p++) begin
      bit eo, ee;
      if (fast_lb_en[p])                      begin eo = m_ll2[p];    ee = 1'b1;       end
      else if (frame_lb_en[p] && chan_mode[p]) begin eo = m_bq[p];     ee = m_boe[p];   end
      else                                     begin eo = play_bit[p]; ee = play_oe[p]; end
      checks++;
      if (ser_out[p] !== eo || ser_oe[p] !== ee) begin
        errors++;
        $display("FAIL %s/%s port %0d: out=%b oe=%b expected out=%b oe=%b",
                 phase, mode_tag(p), p, ser_out[p], ser_oe[p], eo, ee);
      end
    end
  endtask

  // Drive side: own frame position and frame count for stimulus bytes
  int d_pos = 0, d_frame = 0;

  task automatic step(bit fs);
    @(negedge clk);
    fsync = fs;
    if (fs) begin d_pos = 0; d_frame++; end
    else d_pos = (d_pos + 1) % 256;
    for (int p = 0; p < NP; p++) begin
      bit [7:0] by;
      by = 8'(p * 64 + (d_pos / 8) * 7 + d_frame * 13);
      ser_in[p] = by[7 - d_pos % 8];   // R10: MSB first
    end
    play_bit = NP'($urandom);
    play_oe  = NP'($urandom);
    #1;
    compare_ports();
  endtask

  task automatic frame_run(int n);
    step(1'b1);
    for (int i = 1; i < n; i++) step(1'b0);
  endtask

  task automatic cfg_put(int p, int c, logic [15:0] d);
    cfg_we = 1'b1; cfg_port = 2'(p); cfg_chan = 5'(c); cfg_wdata = d;
    step(1'b0);
    cfg_we = 1'b0;
  endtask

  task automatic read_check(int p, int c, logic [15:0] exp, string tag);
    @(negedge clk);
    cfg_port = 2'(p); cfg_chan = 5'(c);
    #1;
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read port %0d chan %0d: got %h expected %h", tag, p, c, cfg_rdata, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    report();
  end

  initial begin
    phase = "R1";
    repeat (3) step(1'b0);
    rst_n = 1'b1;
    read_check(2, 7, 16'h0000, "R1");   // R1: entries invalid after reset
    repeat (5) step(1'b0);
    phase = "R9";
    for (int c = 0; c < 32; c++) begin
      cfg_put(0, c, {1'b1, 10'h000, 5'(c)});            // whole stream
      cfg_put(1, c, {c % 2 == 0, 10'h000, 5'(c)});      // even slots only (R6)
      cfg_put(2, c, {1'b1, 10'h000, 5'(31 - c)});       // reversed order (R7)
      cfg_put(3, c, (c == 0) ? 16'h7FE5 : 16'hFFE5);    // junk in 14:5 (R9)
    end
    read_check(3, 9, 16'h8005, "R9");
    read_check(3, 0, 16'h0005, "R9");
    read_check(2, 4, 16'h801B, "R7");
    phase = "R1";
    frame_lb_en = '1; chan_mode = '1;
    repeat (20) step(1'b0);            // no sync yet: tristated
    phase = "R5";
    repeat (3) frame_run(256);
    phase = "R11";
    frame_run(100);                    // short frame
    phase = "R10";
    repeat (2) frame_run(256);
    step(1'b1);
    phase = "R11";
    repeat (300) step(1'b0);           // wrap without sync
    phase = "R4";
    chan_mode[1] = 1'b0;
    frame_run(256);
    chan_mode[1] = 1'b1;
    phase = "R2";
    fast_lb_en[0] = 1'b1; fast_lb_en[2] = 1'b1;   // port 2 also has frame mode: R3
    frame_run(256);
    phase = "R7";
    fast_lb_en = '0;
    cfg_put(0, 3, {1'b1, 10'h000, 5'd20});        // swap slots 3 and 20 on port 0
    cfg_put(0, 20, {1'b1, 10'h000, 5'd3});
    repeat (2) frame_run(256);
    phase = "R8";
    frame_lb_en = '0;
    frame_run(256);
    report();
  end
endmodule